// File: doc/BRIEF.md
# Segmented Profile Sweep Address Generator

This block produces the read address for a profile RAM split into four segments. Each segment has its own control word: a start address, a final address, a 3-bit mode code and a ramp-rate value. The two profile select inputs choose which control word is active. In static mode the address sits on the start address of the active segment. In ramp-up mode it climbs one location at a time, paced by a rate timer, until it reaches the final address. It then holds there and raises a done flag.

A sweep restarts when the update strobe pulses, when the profile inputs change, or when the RAM enable rises. A restart reloads the start address and the rate timer. While a serial write into the RAM is in progress the busy input freezes the whole generator. A profile change made during that time is acted on once the busy input drops. An update strobe that arrives during busy is dropped.

Top module: `sweep_addr_gen`

## Requirements
- R1: After reset, `rd_addr` is 0 and `sweep_done` is 0.
- R2: While `ram_en` is 0 (and `wr_busy` is 0), `rd_addr` is 0 and `sweep_done` is 0 one cycle later. A rise of `ram_en` restarts a sweep on the selected segment.
- R3: The value on `prof_sel` selects segment k, whose fields sit at bits `[k*W +: W]` of each packed control input (W = field width).
- R4: Mode code 3'b000, and any code other than 3'b001, holds `rd_addr` at the segment start address with no increment, and `sweep_done` stays 0.
- R5: Mode code 3'b001 with ramp-rate N (N ≥ 1) holds each address for N clock cycles and then adds one to the address.
- R6: A ramp-rate value of 0 acts as 1, so the address steps every cycle.
- R7: In ramp-up mode, once `rd_addr` equals the segment final address it stays there and `sweep_done` is 1 until the next restart. This includes the case where the start address equals the final address, in which `sweep_done` rises on the restart itself.
- R8: A one-cycle `upd_stb` pulse restarts the sweep. In the next cycle `rd_addr` is the start address and the rate countdown begins anew.
- R9: Any change of `prof_sel` restarts the sweep on the newly selected segment, in both modes.
- R10: While `wr_busy` is 1, `rd_addr`, `sweep_done` and the rate timer do not change. An `upd_stb` pulse during busy is lost. A `prof_sel` change made during busy causes a restart in the first cycle after `wr_busy` falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| prof_sel | input | PROF_W | Profile select, picks the active segment |
| upd_stb | input | 1 | Single-cycle update strobe, restarts the sweep |
| ram_en | input | 1 | RAM enable; 0 parks the generator at address 0 |
| wr_busy | input | 1 | Serial RAM write in progress; freezes the generator |
| seg_start | input | NPROF*ADDR_W | Packed start addresses, one per segment |
| seg_final | input | NPROF*ADDR_W | Packed final addresses, one per segment |
| seg_mode | input | NPROF*3 | Packed mode codes, one per segment |
| seg_rate | input | NPROF*RATE_W | Packed ramp-rate values, one per segment |
| rd_addr | output | ADDR_W | RAM read address |
| sweep_done | output | 1 | Ramp-up sweep has reached the final address |

## Verification
A rate timer that loads or counts wrongly shows up as an address step landing one or more cycles early or late. This appears within one ramp period of the restart. A wrong final-address compare makes the address run past the final value, or stop short, and `sweep_done` comes out wrong on the very cycle the address should settle. A stale profile register or freeze logic shows up in the first cycle after a profile change or after `wr_busy` falls: the address either fails to reload or reloads when it should not.

// File: rtl/sweep_pkg.sv
package sweep_pkg;
  localparam int MODE_W = 3;

  typedef enum logic [MODE_W-1:0] {
    MODE_STATIC  = 3'b000,
    MODE_RAMP_UP = 3'b001
  } sweep_mode_e;
endpackage

// File: rtl/sweep_seg_mux.sv
module sweep_seg_mux
  import sweep_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int RATE_W = 8,
  parameter int PROF_W = 2,
  localparam int NPROF = 1 << PROF_W
) (
  input  logic [PROF_W-1:0]        sel_i,
  input  logic [NPROF*ADDR_W-1:0]  start_pk_i,
  input  logic [NPROF*ADDR_W-1:0]  final_pk_i,
  input  logic [NPROF*MODE_W-1:0]  mode_pk_i,
  input  logic [NPROF*RATE_W-1:0]  rate_pk_i,
  output logic [ADDR_W-1:0]        start_o,
  output logic [ADDR_W-1:0]        final_o,
  output logic                     is_ramp_o,
  output logic [RATE_W-1:0]        rate_eff_o
);
  logic [ADDR_W-1:0] start_arr [NPROF];
  logic [ADDR_W-1:0] final_arr [NPROF];
  logic [MODE_W-1:0] mode_arr  [NPROF];
  logic [RATE_W-1:0] rate_arr  [NPROF];

  for (genvar g = 0; g < NPROF; g++) begin : g_unpack
    assign start_arr[g] = start_pk_i[g*ADDR_W +: ADDR_W];
    assign final_arr[g] = final_pk_i[g*ADDR_W +: ADDR_W];
    assign mode_arr[g]  = mode_pk_i[g*MODE_W +: MODE_W];
    assign rate_arr[g]  = rate_pk_i[g*RATE_W +: RATE_W];
  end

  assign start_o    = start_arr[sel_i];
  assign final_o    = final_arr[sel_i];
  assign is_ramp_o  = (mode_arr[sel_i] == MODE_RAMP_UP);
  // a zero rate behaves as one cycle per step
  assign rate_eff_o = (rate_arr[sel_i] == '0) ? RATE_W'(1) : rate_arr[sel_i];
endmodule

// File: rtl/sweep_rate_timer.sv
module sweep_rate_timer #(
  parameter int RATE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold_i,
  input  logic              run_i,
  input  logic              load_i,
  input  logic [RATE_W-1:0] rate_i,
  output logic              expire_o
);
  logic [RATE_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (hold_i) begin
      cnt_d = cnt_q;
    end else if (!run_i) begin
      cnt_d = '0;
    end else if (load_i || cnt_q == RATE_W'(1)) begin
      cnt_d = rate_i;
    end else begin
      cnt_d = cnt_q - RATE_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expire_o = run_i && !hold_i && !load_i && (cnt_q == RATE_W'(1));

  // R6
  load_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && run_i && !hold_i) |=> (cnt_q != '0));

  // R10
  timer_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_i |=> $stable(cnt_q));
endmodule

// File: rtl/sweep_addr_ctr.sv
module sweep_addr_ctr #(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold_i,
  input  logic              run_i,
  input  logic              load_i,
  input  logic              step_i,
  input  logic [ADDR_W-1:0] start_i,
  input  logic [ADDR_W-1:0] final_i,
  input  logic              is_ramp_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              done_o
);
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              done_q, done_d;

  always_comb begin
    addr_d = addr_q;
    done_d = done_q;
    if (!hold_i) begin
      if (!run_i) begin
        addr_d = '0;
        done_d = 1'b0;
      end else begin
        if (load_i) begin
          addr_d = start_i;
        end else if (step_i && is_ramp_i && addr_q != final_i) begin
          addr_d = addr_q + ADDR_W'(1);
        end
        done_d = is_ramp_i && (addr_d == final_i);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      done_q <= 1'b0;
    end else begin
      addr_q <= addr_d;
      done_q <= done_d;
    end
  end

  assign addr_o = addr_q;
  assign done_o = done_q;

  // R2
  idle_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i && !hold_i) |=> (addr_q == '0 && !done_q));

  // R8
  restart_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && run_i && !hold_i) |=> (addr_q == $past(start_i)));

  // R5
  unit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !hold_i && !load_i) |=>
      (addr_q == $past(addr_q) || addr_q == $past(addr_q) + ADDR_W'(1)));

  // R4
  static_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !hold_i && !load_i && !is_ramp_i) |=> $stable(addr_q));

  // R7
  final_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && run_i && !hold_i && !load_i) |=> $stable(addr_q));

  // R10
  busy_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_i |=> ($stable(addr_q) && $stable(done_q)));
endmodule

// File: rtl/sweep_addr_gen.sv
module sweep_addr_gen
  import sweep_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int RATE_W = 8,
  parameter int PROF_W = 2,
  localparam int NPROF = 1 << PROF_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [PROF_W-1:0]        prof_sel,
  input  logic                     upd_stb,
  input  logic                     ram_en,
  input  logic                     wr_busy,
  input  logic [NPROF*ADDR_W-1:0]  seg_start,
  input  logic [NPROF*ADDR_W-1:0]  seg_final,
  input  logic [NPROF*MODE_W-1:0]  seg_mode,
  input  logic [NPROF*RATE_W-1:0]  seg_rate,
  output logic [ADDR_W-1:0]        rd_addr,
  output logic                     sweep_done
);
  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // restart detection
  logic [PROF_W-1:0] prof_q, prof_d;
  logic              en_q, en_d;
  logic              restart;

  always_comb begin
    prof_d = prof_q;
    en_d   = en_q;
    if (!wr_busy) begin
      prof_d = prof_sel;
      en_d   = ram_en;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      prof_q <= '0;
      en_q   <= 1'b0;
    end else begin
      prof_q <= prof_d;
      en_q   <= en_d;
    end
  end

  assign restart = ram_en && (upd_stb || (prof_sel != prof_q) || !en_q);

  logic [ADDR_W-1:0] start_sel, final_sel;
  logic              is_ramp;
  logic [RATE_W-1:0] rate_eff;
  logic              step;

  sweep_seg_mux #(.ADDR_W(ADDR_W), .RATE_W(RATE_W), .PROF_W(PROF_W)) i_mux (
    .sel_i      (prof_sel),
    .start_pk_i (seg_start),
    .final_pk_i (seg_final),
    .mode_pk_i  (seg_mode),
    .rate_pk_i  (seg_rate),
    .start_o    (start_sel),
    .final_o    (final_sel),
    .is_ramp_o  (is_ramp),
    .rate_eff_o (rate_eff)
  );

  sweep_rate_timer #(.RATE_W(RATE_W)) i_timer (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .hold_i   (wr_busy),
    .run_i    (ram_en),
    .load_i   (restart),
    .rate_i   (rate_eff),
    .expire_o (step)
  );

  sweep_addr_ctr #(.ADDR_W(ADDR_W)) i_ctr (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .hold_i    (wr_busy),
    .run_i     (ram_en),
    .load_i    (restart),
    .step_i    (step),
    .start_i   (start_sel),
    .final_i   (final_sel),
    .is_ramp_i (is_ramp),
    .addr_o    (rd_addr),
    .done_o    (sweep_done)
  );

  // R9
  prof_restart_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (ram_en && !wr_busy && prof_sel != $past(prof_sel)) |=> (rd_addr == $past(start_sel)));
endmodule

// File: tb/test_sweep_addr_gen.sv
module test_sweep_addr_gen;
  localparam int AW = 10;
  localparam int RW = 8;
  localparam int PW = 2;
  localparam int NP = 1 << PW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [PW-1:0] prof_sel = '0;
  logic upd_stb = 1'b0, ram_en = 1'b0, wr_busy = 1'b0;
  logic [NP*AW-1:0] seg_start, seg_final;
  logic [NP*3-1:0]  seg_mode;
  logic [NP*RW-1:0] seg_rate;
  logic [AW-1:0] rd_addr;
  logic sweep_done;

  int unsigned s_start [NP];
  int unsigned s_final [NP];
  logic [2:0]  s_mode  [NP];
  int unsigned s_rate  [NP];

  always_comb begin
    for (int k = 0; k < NP; k++) begin
      seg_start[k*AW +: AW] = AW'(s_start[k]);
      seg_final[k*AW +: AW] = AW'(s_final[k]);
      seg_mode[k*3 +: 3]    = s_mode[k];
      seg_rate[k*RW +: RW]  = RW'(s_rate[k]);
    end
  end

  sweep_addr_gen #(.ADDR_W(AW), .RATE_W(RW), .PROF_W(PW)) i_sweep_addr_gen (
    .clk(clk), .rst_n(rst_n), .prof_sel(prof_sel), .upd_stb(upd_stb),
    .ram_en(ram_en), .wr_busy(wr_busy), .seg_start(seg_start),
    .seg_final(seg_final), .seg_mode(seg_mode), .seg_rate(seg_rate),
    .rd_addr(rd_addr), .sweep_done(sweep_done)
  );

  always #4 clk = ~clk;

  typedef struct {
    int unsigned addr;
    bit          done;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  // reference state built from the requirements
  int unsigned m_addr = 0, m_cnt = 0;
  bit m_done = 0, m_pen = 0;
  int unsigned m_prev = 0;

  task automatic cyc(input int p, input bit upd, input bit en, input bit busy,
                     input string tag);
    int unsigned r;
    @(negedge clk);
    prof_sel = PW'(p);
    upd_stb  = upd;
    ram_en   = en;
    wr_busy  = busy;
    if (!busy) begin
      r = (s_rate[p] == 0) ? 1 : s_rate[p];
      if (!en) begin
        m_addr = 0; m_cnt = 0; m_done = 0;
      end else begin
        if (upd || p != m_prev || !m_pen) begin
          m_addr = s_start[p]; m_cnt = r;
        end else if (m_cnt == 1) begin
          if (s_mode[p] == 3'b001 && m_addr != s_final[p]) m_addr = (m_addr + 1) % (1 << AW);
          m_cnt = r;
        end else begin
          m_cnt = m_cnt - 1;
        end
        m_done = (s_mode[p] == 3'b001) && (m_addr == s_final[p]);
      end
      m_prev = p;
      m_pen  = en;
    end
    exp_q.push_back('{addr: m_addr, done: m_done, tag: tag});
  endtask

  task automatic run(input int n, input int p, input bit en, input string tag);
    for (int i = 0; i < n; i++) cyc(p, 1'b0, en, 1'b0, tag);
  endtask

  // monitor: pop and compare after each edge
  always @(posedge clk) begin
    #2;
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      n_chk++;
      if (rd_addr !== AW'(e.addr) || sweep_done !== e.done) begin
        n_fail++;
        $display("FAIL %s: addr=%0d done=%0b expected addr=%0d done=%0b",
                 e.tag, rd_addr, sweep_done, e.addr, e.done);
      end
    end
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    // R3: segment k fields at [k*W +: W]
    s_start[0] = 10;  s_final[0] = 13;  s_mode[0] = 3'b001; s_rate[0] = 3;
    s_start[1] = 200; s_final[1] = 210; s_mode[1] = 3'b000; s_rate[1] = 2;
    s_start[2] = 50;  s_final[2] = 52;  s_mode[2] = 3'b001; s_rate[2] = 0;
    s_start[3] = 300; s_final[3] = 300; s_mode[3] = 3'b001; s_rate[3] = 5;
    repeat (3) @(negedge clk);
    n_chk++;
    if (rd_addr !== '0 || sweep_done !== 1'b0) begin
      n_fail++;
      $display("FAIL R1: addr=%0d done=%0b expected addr=0 done=0", rd_addr, sweep_done);
    end
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    n_chk++;
    if (rd_addr !== '0 || sweep_done !== 1'b0) begin
      n_fail++;
      $display("FAIL R1: addr=%0d done=%0b expected addr=0 done=0", rd_addr, sweep_done);
    end

    run(3, 0, 1'b0, "R2 idle");
    run(20, 0, 1'b1, "R5 R7 ramp rate 3");
    cyc(0, 1'b1, 1'b1, 1'b0, "R8 strobe");
    run(5, 0, 1'b1, "R8 after strobe");
    run(8, 1, 1'b1, "R4 R9 static");
    cyc(1, 1'b1, 1'b1, 1'b0, "R4 strobe static");
    run(3, 1, 1'b1, "R4 static");
    run(8, 2, 1'b1, "R6 R3 rate zero");
    run(6, 3, 1'b1, "R7 start equals final");
    run(4, 0, 1'b1, "R9 back to 0");
    for (int i = 0; i < 4; i++) cyc(1, 1'b0, 1'b1, 1'b1, "R10 busy prof change");
    cyc(1, 1'b1, 1'b1, 1'b1, "R10 busy strobe");
    run(4, 1, 1'b1, "R10 after busy");
    run(5, 0, 1'b1, "R10 restart p0");
    for (int i = 0; i < 3; i++) cyc(0, 1'b1, 1'b1, 1'b1, "R10 strobe lost");
    run(12, 0, 1'b1, "R10 resume");
    run(3, 0, 1'b0, "R2 disable");
    run(6, 0, 1'b1, "R2 re-enable");
    s_mode[1] = 3'b110;
    run(6, 1, 1'b1, "R4 other code");
    run(4, 2, 1'b1, "R6 R9 p2 again");

    @(posedge clk);
    #3;
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule